// File: doc/BRIEF.md
# Pointer-Addressed Control Register Bank

This block holds 128 seven-bit control registers behind one CPU I/O port. A CPU write whose data bit 7 is set points the block at a register. A write with bit 7 clear stores the lower seven data bits in the register it points to, then moves the pointer to the next register. Block-output instructions can therefore fill a run of registers with one pointer write and a stream of data writes. A read returns the register under the pointer and leaves the pointer where it is, so software can read a register, modify it and write it back.

The whole bank is also presented as a flat parallel vector for the video logic. Bit 6 of register 96 is a sticky lock. Once it is set, the block stops answering on its port. It also reports every I/O access with address bit 0 low as belonging to the legacy port. Only reset clears the lock.

Top module: `ctrl_regbank`

## Requirements
- R1: The block claims an access (`enh_sel` = 1) when io_addr[0] = 0 and io_addr[7:5] = 3'b011 and the lock is clear, whatever io_addr[15:8] and io_addr[4:1] hold.
- R2: A claimed write with io_wdata[7] = 1 loads io_wdata[6:0] into the pointer and changes no register.
- R3: A claimed write with io_wdata[7] = 0 stores io_wdata[6:0] into the register under the pointer and then increments the pointer.
- R4: A claimed read returns {1'b0, register[pointer]} on io_rdata in the same cycle and does not move the pointer.
- R5: Incrementing the pointer from 127 gives 0.
- R6: Reset clears all registers, the pointer and the lock to 0.
- R7: A store of a value with bit 6 set into register 96 sets `locked`. From then on no write changes any register, and io_rdata stays 0, until reset.
- R8: `classic_sel` is 1 when io_addr[0] = 0 and either io_addr[7:5] = 3'b111 or the lock is set. The two select outputs are never 1 together.
- R9: Accesses with io_addr[0] = 1, or with io_addr[7:5] other than 3'b011, change no register and no pointer, and read back as 0.
- R10: Register k appears on reg_view[7k+6:7k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | CPU I/O address |
| io_wdata | input | 8 | CPU write data |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, 0 when the access is not claimed |
| enh_sel | output | 1 | The access addresses this bank |
| classic_sel | output | 1 | The access belongs to the legacy port |
| locked | output | 1 | Sticky lock state |
| reg_view | output | 896 | All registers, 7 bits each, register 0 lowest |

## Verification
A write is taken on the rising edge during its strobe. Its register, pointer and lock effects are therefore visible one cycle later. Reads and both select outputs follow the address combinationally in the same cycle. Only the lock's effect on the selects lags its triggering write by one edge. The bench drives strobes on falling edges, lets exactly one rising edge pass before it looks at any write effect, and samples reads a short delay after the inputs settle, never at a rising edge.

// File: rtl/regbank_pkg.sv
`timescale 1ns/1ps
package regbank_pkg;
    localparam int unsigned NREGS    = 128;
    localparam int unsigned DW       = 7;
    localparam int unsigned BUSW     = DW + 1;
    localparam int unsigned PW       = $clog2(NREGS);
    localparam int unsigned VIEWW    = NREGS * DW;
    localparam int unsigned LOCK_REG = 96;
    localparam int unsigned LOCK_BIT = 6;

    typedef logic [PW-1:0] ptr_t;
    typedef logic [DW-1:0] val_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_SEL   = 2'd1,
        OP_STORE = 2'd2
    } wop_e;

    typedef struct packed {
        wop_e op;
        ptr_t ptr;
        val_t val;
    } wreq_t;

    function automatic wop_e classify(input logic wr, input logic hit, input logic d7);
        if (!(wr && hit)) return OP_NONE;
        return d7 ? OP_SEL : OP_STORE;
    endfunction

    function automatic ptr_t ptr_next(input ptr_t p);
        return (p == ptr_t'(NREGS - 1)) ? ptr_t'(0) : ptr_t'(p + ptr_t'(1));
    endfunction
endpackage

// File: rtl/port_decode.sv
`timescale 1ns/1ps
module port_decode
    import regbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] addr_lo,
    input  logic       lock_set,
    output logic       enh_hit,
    output logic       cls_hit,
    output logic       locked
);
    logic       lock_q;
    logic [2:0] grp;

    always_ff @(posedge clk) begin
        if (rst)           lock_q <= 1'b0;
        else if (lock_set) lock_q <= 1'b1;
    end

    // The lock forces the top group bit high, so this port drops out of the decode.
    assign grp     = {addr_lo[7] | lock_q, addr_lo[6], addr_lo[5]};
    assign enh_hit = !addr_lo[0] && (grp == 3'b011);
    assign cls_hit = !addr_lo[0] && (lock_q || (addr_lo[7:5] == 3'b111));
    assign locked  = lock_q;

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst) locked |=> locked);
    // R7
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(locked) |-> $past(lock_set));
    // R8
    sel_excl_chk: assert property (@(posedge clk) disable iff (rst) !(enh_hit && cls_hit));
endmodule

// File: rtl/ptr_ctrl.sv
`timescale 1ns/1ps
module ptr_ctrl
    import regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wreq_t req,
    output ptr_t  ptr
);
    ptr_t ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            unique case (req.op)
                OP_SEL:   ptr_q <= req.val[PW-1:0];
                OP_STORE: ptr_q <= ptr_next(ptr_q);
                default:  ptr_q <= ptr_q;
            endcase
        end
    end

    assign ptr = ptr_q;

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (req.op == OP_SEL) |=> (ptr == $past(req.val[PW-1:0])));
    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (req.op == OP_STORE && ptr == ptr_t'(NREGS - 1)) |=> (ptr == '0));
    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req.op == OP_NONE) |=> $stable(ptr));
endmodule

// File: rtl/reg_array.sv
`timescale 1ns/1ps
module reg_array
    import regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wreq_t            req,
    input  ptr_t             rd_ptr,
    output val_t             rd_val,
    output logic [VIEWW-1:0] view
);
    val_t regs [NREGS];

    for (genvar k = 0; k < NREGS; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[k] <= '0;
            else if (req.op == OP_STORE && req.ptr == ptr_t'(k))
                regs[k] <= req.val;
        end
        assign view[k*DW +: DW] = regs[k];
    end

    assign rd_val = regs[rd_ptr];

    // R3
    store_land_chk: assert property (@(posedge clk) disable iff (rst)
        (req.op == OP_STORE) |=> (regs[$past(req.ptr)] == $past(req.val)));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req.op != OP_STORE) |=> $stable(view));
endmodule

// File: rtl/ctrl_regbank.sv
`timescale 1ns/1ps
module ctrl_regbank
    import regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       io_addr,
    input  logic [BUSW-1:0]   io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [BUSW-1:0]   io_rdata,
    output logic              enh_sel,
    output logic              classic_sel,
    output logic              locked,
    output logic [VIEWW-1:0]  reg_view
);
    logic  enh_hit, cls_hit, lock_q, lock_set;
    ptr_t  ptr;
    val_t  rd_val;
    wreq_t req;
    logic  unused_addr;

    assign unused_addr = ^{io_addr[15:8], io_addr[4:1]};

    port_decode u_dec (
        .clk(clk), .rst(rst), .addr_lo(io_addr[7:0]), .lock_set(lock_set),
        .enh_hit(enh_hit), .cls_hit(cls_hit), .locked(lock_q)
    );

    always_comb begin
        req.op  = classify(io_wr, enh_hit, io_wdata[BUSW-1]);
        req.ptr = ptr;
        req.val = io_wdata[DW-1:0];
    end

    assign lock_set = (req.op == OP_STORE) && (ptr == ptr_t'(LOCK_REG)) && io_wdata[LOCK_BIT];

    ptr_ctrl u_ptr (.clk(clk), .rst(rst), .req(req), .ptr(ptr));

    reg_array u_regs (
        .clk(clk), .rst(rst), .req(req), .rd_ptr(ptr), .rd_val(rd_val), .view(reg_view)
    );

    assign io_rdata    = (io_rd && enh_hit) ? {1'b0, rd_val} : '0;
    assign enh_sel     = enh_hit;
    assign classic_sel = cls_hit;
    assign locked      = lock_q;

    // R4
    rd_msb_chk: assert property (@(posedge clk) disable iff (rst) !io_rdata[BUSW-1]);
    // R7
    locked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(reg_view));
endmodule

// File: tb/test_ctrl_regbank.sv
`timescale 1ns/1ps
module test_ctrl_regbank;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [15:0]  io_addr = '0;
    logic [7:0]   io_wdata = '0;
    logic         io_wr = 1'b0;
    logic         io_rd = 1'b0;
    logic [7:0]   io_rdata;
    logic         enh_sel, classic_sel, locked;
    logic [895:0] reg_view;
    logic [895:0] snap;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ctrl_regbank i_ctrl_regbank (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .enh_sel(enh_sel),
        .classic_sel(classic_sel), .locked(locked), .reg_view(reg_view)
    );

    typedef struct packed {
        logic        is_rd;
        logic [15:0] addr;
        logic [7:0]  data;   // write data, or expected read data
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0, 16'h0060, 8'h85},  // R2 point at 5
        '{1'b0, 16'h1260, 8'h11},  // R3 reg5 = 11, ptr 6; R1 upper byte ignored
        '{1'b0, 16'hFF7E, 8'h22},  // R3 reg6 = 22, ptr 7; R1 bits 4:1 ignored
        '{1'b0, 16'h0060, 8'h85},  // R2 back to 5
        '{1'b1, 16'h0060, 8'h11},  // R4 read reg5
        '{1'b1, 16'h3360, 8'h11},  // R4 pointer unchanged
        '{1'b0, 16'h0060, 8'h33},  // R3 modify reg5, ptr 6
        '{1'b1, 16'h0060, 8'h22},  // R3 pointer advanced
        '{1'b0, 16'h0061, 8'h80},  // R9 odd address ignored
        '{1'b1, 16'h0060, 8'h22},  // R9
        '{1'b0, 16'h00E0, 8'h81},  // R9 group 111 ignored
        '{1'b1, 16'h0060, 8'h22},  // R9
        '{1'b0, 16'h0040, 8'h81},  // R9 group 010 ignored
        '{1'b1, 16'h0060, 8'h22},  // R9
        '{1'b1, 16'h0061, 8'h00},  // R9 unclaimed read returns 0
        '{1'b0, 16'h0060, 8'h85},  // R2
        '{1'b1, 16'h0060, 8'h33},  // R4 read-modify-write result
        '{1'b0, 16'h0060, 8'h7F}   // R3 full 7-bit value into reg5, ptr 6
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        #400000;
        total++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R6 reset state
        check(reg_view == '0, "R6 regs", 0, 0);
        check(locked == 1'b0, "R6 lock", locked, 0);
        rd(16'h0060, r);
        check(r == 8'h00, "R6 read", r, 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_rd) begin
                rd(VEC[i].addr, r);
                check(r == VEC[i].data, $sformatf("R4 vector %0d", i), r, VEC[i].data);
            end else begin
                wr(VEC[i].addr, VEC[i].data);
            end
        end

        // R10 register 5 and 6 positions in the view
        check(reg_view[35 +: 7] == 7'h7F, "R10 reg5", reg_view[35 +: 7], 7'h7F);
        check(reg_view[42 +: 7] == 7'h22, "R10 reg6", reg_view[42 +: 7], 7'h22);

        // R5 wrap from 127 to 0
        wr(16'h0060, 8'hFF);
        wr(16'h0060, 8'h55);
        wr(16'h0060, 8'h66);
        check(reg_view[889 +: 7] == 7'h55, "R5 reg127", reg_view[889 +: 7], 7'h55);
        check(reg_view[0 +: 7] == 7'h66, "R5 reg0", reg_view[0 +: 7], 7'h66);
        rd(16'h0060, r);
        check(r == 8'h00, "R5 ptr now 1", r, 0);

        // R1 and R8 select decode while unlocked
        @(negedge clk); io_addr = 16'hAB60; #1;
        check(enh_sel == 1'b1, "R1 sel 0xAB60", enh_sel, 1);
        check(classic_sel == 1'b0, "R8 no classic 0xAB60", classic_sel, 0);
        io_addr = 16'h00FE; #1;
        check(classic_sel == 1'b1 && enh_sel == 1'b0, "R8 classic 0x00FE", classic_sel, 1);
        io_addr = 16'h0020; #1;
        check(classic_sel == 1'b0 && enh_sel == 1'b0, "R8 none 0x0020", classic_sel, 0);

        // R7 set lock via reg96 bit6
        wr(16'h0060, 8'hE0);
        wr(16'h0060, 8'h40);
        #1;
        check(locked == 1'b1, "R7 lock set", locked, 1);
        check(reg_view[672 +: 7] == 7'h40, "R10 reg96", reg_view[672 +: 7], 7'h40);
        io_addr = 16'h0060; #1;
        check(enh_sel == 1'b0, "R7 port off", enh_sel, 0);
        check(classic_sel == 1'b1, "R8 locked 0x0060 classic", classic_sel, 1);
        io_addr = 16'h0020; #1;
        check(classic_sel == 1'b1, "R8 locked 0x0020 classic", classic_sel, 1);
        snap = reg_view;
        wr(16'h0060, 8'h85);
        wr(16'h0060, 8'h12);
        #1;
        check(reg_view == snap, "R7 writes ignored", 0, 0);
        rd(16'h0060, r);
        check(r == 8'h00, "R7 read off", r, 0);

        // R6 reset clears everything, including the lock
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check(locked == 1'b0, "R6 lock cleared", locked, 0);
        check(reg_view == '0, "R6 regs cleared", 0, 0);
        wr(16'h0060, 8'h09);
        check(reg_view[0 +: 7] == 7'h09, "R6 ptr cleared", reg_view[0 +: 7], 7'h09);

        finish_run();
    end
endmodule